// File: doc/BRIEF.md
# Inter-Core Mailbox Register File

This block keeps sixteen 32-bit mailbox words, four owned by each of four cores, so that processors can signal one another. Any bus agent raises bits in a mailbox through a write-to-set window and drops them through a write-to-clear window. The clear window is also where the mailbox contents are read back. Both operations work bit by bit, so a mailbox stays pending until every bit that was raised has been cleared.

Every nonzero mailbox is pending. Each core has a small mailbox control register that routes each of its four mailboxes to a fast-interrupt line, to a normal-interrupt line, or to neither. The resulting per-mailbox request vectors go to an interrupt router outside this block. Several write ports can reach the register file in the same cycle. A single read port returns data one cycle after the request.

Top module: `mbox_regfile`

## Requirements
- R1: After reset every mailbox and every control register holds zero, `rd_data` is zero and no request output is high.
- R2: A write to byte address 0x80 + 4·n ORs the write data into mailbox n (n = 0..15), and bits already set are kept.
- R3: A write to byte address 0xC0 + 4·n clears in mailbox n each bit that is 1 in the write data, and leaves the other bits as they were.
- R4: A read with `rd_en` high at 0xC0 + 4·n puts the value of mailbox n on `rd_data` in the next cycle. That value is the contents before any write in the request cycle. `rd_data` holds its value until the next read.
- R5: A read in the set window (0x80..0xBF), or at any address that no register decodes, returns zero.
- R6: Mailbox n is pending exactly when its value is nonzero. Clearing only some of its set bits leaves it pending.
- R7: Mailbox n belongs to core c = n/4 with local index j = n mod 4. When it is pending, `fiq_pend[n]` is high if bit j+4 of core c's control register is 1. Otherwise `irq_pend[n]` is high if bit j is 1. Otherwise both outputs are low.
- R8: Core c's control register sits at 0x50 + 4·c. A write stores data bits [7:0] and drops the upper bits. A read returns the stored byte, zero-extended.
- R9: When a clear and a set reach the same mailbox in one cycle, the clear is applied first and then the set. Sets from several ports to one mailbox in one cycle all accumulate.
- R10: When several ports write the same control register in one cycle, the highest-numbered port's data is stored.
- R11: Writes to addresses that no register decodes change no mailbox and no control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | NPORTS (2) | Write strobe, one per port |
| wr_addr | input | NPORTS·AW (16) | Byte address per port, port p in bits [p·AW +: AW] |
| wr_data | input | NPORTS·DW (64) | Write data per port, port p in bits [p·DW +: DW] |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW (8) | Read byte address |
| rd_data | output | DW (32) | Read data, valid the cycle after `rd_en` |
| irq_pend | output | 16 | Normal-interrupt request per mailbox |
| fiq_pend | output | 16 | Fast-interrupt request per mailbox |

## Verification
The bench builds the block with its defaults: four cores of four mailboxes, two write ports, an 8-bit address and 32-bit data. With two write ports it can put a clear and a set on the same mailbox, or two conflicting control writes, into a single cycle, so the ordering rules are exercised directly. Using all sixteen mailboxes reaches the last index of the last core. That checks the core/index split and the fast-interrupt bit at the top of the control byte.

// File: rtl/mbox_regfile.sv
module mbox_regfile #(
  parameter int NCORES    = 4,
  parameter int MBPC      = 4,
  parameter int NPORTS    = 2,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CTRL_BASE = 'h50,
  parameter int SET_BASE  = 'h80,
  parameter int CLR_BASE  = 'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    wr_en,
  input  logic [NPORTS*AW-1:0] wr_addr,
  input  logic [NPORTS*DW-1:0] wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [NCORES*MBPC-1:0] irq_pend,
  output logic [NCORES*MBPC-1:0] fiq_pend
);
  localparam int NMB = NCORES * MBPC;
  localparam int CW  = 2 * MBPC;

  logic [DW-1:0]     mb       [NMB];
  logic [CW-1:0]     ctl      [NCORES];
  logic [DW-1:0]     set_mask [NMB];
  logic [DW-1:0]     clr_mask [NMB];
  logic [NCORES-1:0] ctl_we;
  logic [CW-1:0]     ctl_wd   [NCORES];
  logic [DW-1:0]     rd_mux;

  always_comb begin
    for (int n = 0; n < NMB; n++) begin
      set_mask[n] = '0;
      clr_mask[n] = '0;
    end
    for (int c = 0; c < NCORES; c++) begin
      ctl_we[c] = 1'b0;
      ctl_wd[c] = '0;
    end
    for (int p = 0; p < NPORTS; p++) begin
      if (wr_en[p]) begin
        for (int n = 0; n < NMB; n++) begin
          if (wr_addr[p*AW +: AW] == AW'(SET_BASE + 4*n)) set_mask[n] = set_mask[n] | wr_data[p*DW +: DW];
          if (wr_addr[p*AW +: AW] == AW'(CLR_BASE + 4*n)) clr_mask[n] = clr_mask[n] | wr_data[p*DW +: DW];
        end
        for (int c = 0; c < NCORES; c++) begin
          if (wr_addr[p*AW +: AW] == AW'(CTRL_BASE + 4*c)) begin
            ctl_we[c] = 1'b1;
            ctl_wd[c] = wr_data[p*DW +: CW];
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NMB; n++)
      if (rd_addr == AW'(CLR_BASE + 4*n)) rd_mux = mb[n];
    for (int c = 0; c < NCORES; c++)
      if (rd_addr == AW'(CTRL_BASE + 4*c)) rd_mux = DW'(ctl[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NMB; n++) mb[n] <= '0;
      for (int c = 0; c < NCORES; c++) ctl[c] <= '0;
      rd_data <= '0;
    end else begin
      for (int n = 0; n < NMB; n++) mb[n] <= (mb[n] & ~clr_mask[n]) | set_mask[n];
      for (int c = 0; c < NCORES; c++) if (ctl_we[c]) ctl[c] <= ctl_wd[c];
      if (rd_en) rd_data <= rd_mux;
    end
  end

  for (genvar n = 0; n < NMB; n++) begin : g_mb
    localparam int C = n / MBPC;
    localparam int J = n % MBPC;
    assign fiq_pend[n] = (|mb[n]) && ctl[C][J+MBPC];
    assign irq_pend[n] = (|mb[n]) && !ctl[C][J+MBPC] && ctl[C][J];

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask[n] != '0) |=> ((mb[n] & $past(set_mask[n])) == $past(set_mask[n]))); // R9
    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[n] != '0 && set_mask[n] == '0) |=> ((mb[n] & $past(clr_mask[n])) == '0)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[n] == '0 && set_mask[n] == '0) |=> $stable(mb[n])); // R11
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_pend[n] |-> !irq_pend[n]); // R7
    AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[n] || fiq_pend[n]) |-> (mb[n] != '0)); // R6
  end
endmodule

// File: tb/tb_mbox_regfile.sv
`timescale 1ns/100ps
module tb_mbox_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wr_en = '0;
  logic [15:0] wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_pend, fiq_pend;

  mbox_regfile dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_pend(irq_pend), .fiq_pend(fiq_pend));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_mb [16];
  logic [7:0]  m_ctl [4];
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic        issued = 1'b0;

  function automatic logic [31:0] mread(int a);
    if (a >= 'hC0 && a < 'h100 && a % 4 == 0) return m_mb[(a - 'hC0) / 4];
    if (a >= 'h50 && a < 'h60 && a % 4 == 0) return {24'h0, m_ctl[(a - 'h50) / 4]};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) issued <= rd_en && rst_n;
  always @(negedge clk) begin
    if (issued) begin
      if (q_exp.size() == 0) check("R4 unexpected read", rd_data, 32'h0);
      else check(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = '0; rd_en = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) m_mb[i] = '0;
    for (int i = 0; i < 4; i++) m_ctl[i] = '0;
    rst_n = 1;
  endtask

  task automatic wr2(logic [1:0] en, int a0, logic [31:0] d0, int a1, logic [31:0] d1);
    int a [2];
    logic [31:0] d [2];
    @(negedge clk);
    wr_en = en; wr_addr = {a1[7:0], a0[7:0]}; wr_data = {d1, d0};
    a[0] = a0; a[1] = a1; d[0] = d0; d[1] = d1;
    for (int p = 0; p < 2; p++)
      if (en[p] && a[p] >= 'hC0 && a[p] < 'h100 && a[p] % 4 == 0) m_mb[(a[p]-'hC0)/4] &= ~d[p];
    for (int p = 0; p < 2; p++)
      if (en[p] && a[p] >= 'h80 && a[p] < 'hC0 && a[p] % 4 == 0) m_mb[(a[p]-'h80)/4] |= d[p];
    for (int p = 0; p < 2; p++)
      if (en[p] && a[p] >= 'h50 && a[p] < 'h60 && a[p] % 4 == 0) m_ctl[(a[p]-'h50)/4] = d[p][7:0];
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr2(2'b01, a, d, 0, 32'h0);
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    rd_addr = a[7:0]; rd_en = 1;
    q_exp.push_back(mread(a)); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic chk_pend(string tag);
    logic [15:0] ei, ef;
    for (int n = 0; n < 16; n++) begin
      ef[n] = (m_mb[n] != 0) && m_ctl[n/4][n%4+4];
      ei[n] = (m_mb[n] != 0) && !m_ctl[n/4][n%4+4] && m_ctl[n/4][n%4];
    end
    @(negedge clk);
    check({tag, " irq"}, {16'h0, irq_pend}, {16'h0, ei});
    check({tag, " fiq"}, {16'h0, fiq_pend}, {16'h0, ef});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 rd_data", rd_data, 32'h0);
    chk_pend("R1 pend");
    rd('hC0 + 4*5, "R1 mb5");
    rd('h50 + 4*2, "R1 ctl2");

    wr('h80 + 4*3, 32'h0000_00F0);
    rd('hC0 + 4*3, "R2 R4 mb3 first set");
    wr('h80 + 4*3, 32'h0000_000F);
    rd('hC0 + 4*3, "R2 mb3 accumulate");
    rd('h80 + 4*3, "R5 set window read");
    rd('h10, "R5 unmapped read");

    wr('h50, 32'h08);
    chk_pend("R7 irq mb3");
    rd('h50, "R8 ctl0");

    wr('hC0 + 4*3, 32'h0000_000F);
    chk_pend("R6 partial clear pending");
    rd('hC0 + 4*3, "R3 mb3 partial");
    wr('hC0 + 4*3, 32'h0000_00F0);
    chk_pend("R6 fully cleared");
    rd('hC0 + 4*3, "R3 mb3 zero");

    wr('h50 + 4*2, 32'h11);
    wr('h80 + 4*8, 32'h1);
    chk_pend("R7 fiq wins mb8");
    wr('h50 + 4*2, 32'h01);
    chk_pend("R7 irq mb8");
    wr('h50 + 4*2, 32'h00);
    chk_pend("R7 masked mb8");

    wr('h80 + 4*10, 32'h3C);
    wr2(2'b11, 'hC0 + 4*10, 32'hFFFF_FFFF, 'h80 + 4*10, 32'hA5);
    rd('hC0 + 4*10, "R9 clear then set");
    wr2(2'b11, 'h80 + 4*10, 32'h0100_0000, 'h80 + 4*10, 32'h0002_0000);
    rd('hC0 + 4*10, "R9 sets accumulate");

    wr2(2'b11, 'h50 + 4*1, 32'h01, 'h50 + 4*1, 32'h02);
    rd('h50 + 4*1, "R10 last port wins");

    wr('h04, 32'hFFFF_FFFF);
    wr('h44, 32'hFFFF_FFFF);
    wr('hC2, 32'hFFFF_FFFF);
    rd('hC0 + 4*10, "R11 mb10 untouched");
    rd('h50 + 4*1, "R11 ctl1 untouched");
    chk_pend("R11 pend untouched");

    wr('h50 + 4*3, 32'h1FF);
    rd('h50 + 4*3, "R8 low byte only");
    wr('h80 + 4*15, 32'h8000_0000);
    chk_pend("R7 fiq mb15");
    rd('hC0 + 4*15, "R2 mb15");

    do_reset();
    @(negedge clk);
    chk_pend("R1 pend after reset");
    rd('hC0 + 4*15, "R1 mb15 after reset");
    rd('h50 + 4*3, "R1 ctl3 after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule